// File: doc/BRIEF.md
# Gated Decade Event Counter with Readout Latch

This block counts events on a synchronised pulse input across a chain of binary-coded decimal decades. A count is added only while the gate enable is high, so the running total equals the event rate multiplied by the time the gate stays open. The input is sampled on every clock, and each rising edge adds one count. When the count passes the top decade it wraps, and a sticky over-range flag is set.

An active-low display strobe copies the running total, the over-range flag and the interval selection into a readout register. An active-low clear strobe sets the running total and its over-range flag back to zero. The readout register holds its value between display strobes. The latched interval selection sets the decimal-point position and the units code, so that the digits read as a frequency in Hz, kHz or MHz.

Top module: `gated_bcd_counter`

## Requirements
- R1: Every 4-bit digit of the running total and of `rd_digits` holds a value from 0 to 9. Digit k sits at bits [4k+3:4k], so the least significant decade is at bits [3:0].
- R2: The running total changes only at a clock edge where `gate` is high.
- R3: `evt_in` is sampled at each clock edge. A 0-to-1 change between two samples adds exactly one count, however long the input then stays high.
- R4: At an edge where `clr_n` is low, the running total and the running over-range flag become zero. This takes precedence over any count arriving at the same edge.
- R5: At an edge where `disp_n` is low, `rd_digits`, `rd_ovr` and the latched interval take the values held just before that edge. Otherwise they hold, and a clear leaves them untouched.
- R6: A decade that counts past 9 returns to 0 and carries into the next decade. The total wraps modulo 10^DIGITS.
- R7: A carry out of the top decade sets the running over-range flag. The flag stays set until a clear.
- R8: With a latched interval s (0..7, gate time 10^s µs), `rd_dp` equals s mod 3 and gives the number of digits right of the point. `rd_unit` is 2 (MHz) for s 0..2, 1 (kHz) for s 3..5 and 0 (Hz) for s 6..7.
- R9: Asynchronous `rst_n` low clears every register. The readout then shows zero digits, no over-range, `rd_dp` 0 and `rd_unit` 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Event input, already synchronised to `clk` |
| gate | input | 1 | Count enable |
| disp_n | input | 1 | Active-low readout transfer strobe |
| clr_n | input | 1 | Active-low running-count clear |
| ivl_sel | input | 3 | Gate interval selection, 10^sel µs |
| rd_digits | output | 4*DIGITS | Latched BCD digits |
| rd_dp | output | 2 | Digits right of the decimal point |
| rd_unit | output | 2 | Units code: 0 Hz, 1 kHz, 2 MHz |
| rd_ovr | output | 1 | Latched over-range flag |

## Verification
The assertions assume that `evt_in`, `gate`, `disp_n` and `clr_n` are already synchronous to `clk` and stable around the sampling edge. They make no assumption about how strobes overlap with counting. The stimulus changes every input only on falling clock edges and spaces single events one cycle apart, so each rising edge is seen once. It also deliberately overlaps a display strobe with a clear, and a clear with an event, to exercise the precedence rules. A second instance with two decades makes wrap and over-range reachable within a short run.

// File: rtl/gated_bcd_counter.sv
module gated_bcd_counter #(
  parameter int DIGITS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evt_in,
  input  logic                  gate,
  input  logic                  disp_n,
  input  logic                  clr_n,
  input  logic [2:0]            ivl_sel,
  output logic [4*DIGITS-1:0]   rd_digits,
  output logic [1:0]            rd_dp,
  output logic [1:0]            rd_unit,
  output logic                  rd_ovr
);
  localparam int W = 4 * DIGITS;

  logic          evt_q;
  logic          rise;
  logic [W-1:0]  cnt;
  logic [W-1:0]  cnt_nx;
  logic [DIGITS:0] cy;
  logic          ovr_run;
  logic [2:0]    sel_q;

  assign rise  = evt_in & ~evt_q;
  assign cy[0] = rise & gate;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    logic [3:0] d;
    assign d = cnt[4*g +: 4];
    assign cy[g+1] = cy[g] & (d == 4'd9);
    assign cnt_nx[4*g +: 4] = !cy[g] ? d : (d == 4'd9) ? 4'd0 : d + 4'd1;

    AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[4*g +: 4] <= 4'd9 && rd_digits[4*g +: 4] <= 4'd9); // R1
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q     <= 1'b0;
      cnt       <= '0;
      ovr_run   <= 1'b0;
      rd_digits <= '0;
      rd_ovr    <= 1'b0;
      sel_q     <= '0;
    end else begin
      evt_q <= evt_in;
      if (!clr_n) begin
        cnt     <= '0;
        ovr_run <= 1'b0;
      end else begin
        cnt <= cnt_nx;
        if (cy[DIGITS]) ovr_run <= 1'b1;
      end
      if (!disp_n) begin
        rd_digits <= cnt;
        rd_ovr    <= ovr_run;
        sel_q     <= ivl_sel;
      end
    end
  end

  always_comb begin
    case (sel_q)
      3'd0, 3'd3, 3'd6: rd_dp = 2'd0;
      3'd1, 3'd4, 3'd7: rd_dp = 2'd1;
      default:          rd_dp = 2'd2;
    endcase
    if (sel_q < 3'd3)      rd_unit = 2'd2;
    else if (sel_q < 3'd6) rd_unit = 2'd1;
    else                   rd_unit = 2'd0;
  end

  AST_GATE_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && clr_n) |=> $stable(cnt)); // R2
  AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && evt_q && evt_in) |=> $stable(cnt)); // R3
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (cnt == '0 && !ovr_run)); // R4
  AST_READOUT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_n |=> (rd_digits == $past(cnt) && rd_ovr == $past(ovr_run))); // R5
  AST_READOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    disp_n |=> ($stable(rd_digits) && $stable(rd_ovr) && $stable(rd_dp) && $stable(rd_unit))); // R5
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && cy[DIGITS]) |=> ovr_run); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ovr_run) |=> ovr_run); // R7
endmodule

// File: tb/tb_gated_bcd_counter.sv
module tb_gated_bcd_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_in = 1'b0, gate = 1'b0, disp_n = 1'b1, clr_n = 1'b1;
  logic [2:0] ivl_sel = 3'd0;
  logic [23:0] rd_big;
  logic [7:0]  rd_sm;
  logic [1:0]  dp_big, unit_big, dp_sm, unit_sm;
  logic        ovr_big, ovr_sm;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gated_bcd_counter dut (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .gate(gate),
    .disp_n(disp_n), .clr_n(clr_n), .ivl_sel(ivl_sel), .rd_digits(rd_big),
    .rd_dp(dp_big), .rd_unit(unit_big), .rd_ovr(ovr_big));

  gated_bcd_counter #(.DIGITS(2)) dut_small (.clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .gate(gate), .disp_n(disp_n), .clr_n(clr_n), .ivl_sel(ivl_sel), .rd_digits(rd_sm),
    .rd_dp(dp_sm), .rd_unit(unit_sm), .rd_ovr(ovr_sm));

  function automatic int bcd2int(input logic [23:0] v, input int nd);
    int r = 0;
    for (int k = nd - 1; k >= 0; k--) r = r * 10 + int'(v[4*k +: 4]);
    return r;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clear();
    @(negedge clk) clr_n = 1'b0;
    @(negedge clk) clr_n = 1'b1;
  endtask

  task automatic show(input int s);
    @(negedge clk) begin ivl_sel = 3'(s); disp_n = 1'b0; end
    @(negedge clk) disp_n = 1'b1;
  endtask

  task automatic pulses(input int n);
    repeat (n) begin
      @(negedge clk) evt_in = 1'b1;
      @(negedge clk) evt_in = 1'b0;
    end
  endtask

  task automatic run_count(input int n);
    clear();
    @(negedge clk) gate = 1'b1;
    pulses(n);
    @(negedge clk) gate = 1'b0;
    show(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 digits", bcd2int(rd_big, 6), 0);
    chk("R9 ovr", int'(ovr_big), 0);
    chk("R9 dp", int'(dp_big), 0);
    chk("R9 unit", int'(unit_big), 2);

    // R6 R7 near-exhaustive sweep on the two-decade instance
    for (int n = 0; n <= 130; n++) begin
      run_count(n);
      chk("R6 big", bcd2int(rd_big, 6), n);
      chk("R6 small", bcd2int({16'd0, rd_sm}, 2), n % 100);
      chk("R7 small ovr", int'(ovr_sm), int'(n >= 100));
      chk("R7 big ovr", int'(ovr_big), 0);
    end
    run_count(9999);
    chk("R6 big 9999", bcd2int(rd_big, 6), 9999);
    run_count(10001);
    chk("R6 big 10001", bcd2int(rd_big, 6), 10001);

    // R2 gate closed
    clear();
    pulses(5);
    @(negedge clk) gate = 1'b1;
    pulses(3);
    @(negedge clk) gate = 1'b0;
    pulses(4);
    show(6);
    chk("R2 gated", bcd2int(rd_big, 6), 3);

    // R3 held-high input
    clear();
    @(negedge clk) gate = 1'b1;
    @(negedge clk) evt_in = 1'b1;
    repeat (10) @(negedge clk);
    evt_in = 1'b0;
    @(negedge clk) evt_in = 1'b1;
    repeat (5) @(negedge clk);
    evt_in = 1'b0;
    @(negedge clk) gate = 1'b0;
    show(6);
    chk("R3 held", bcd2int(rd_big, 6), 2);

    // R7 sticky, R5 clear leaves readout
    run_count(105);
    chk("R7 sticky ovr", int'(ovr_sm), 1);
    chk("R7 sticky digits", bcd2int({16'd0, rd_sm}, 2), 5);
    clear();
    @(negedge clk);
    chk("R5 clear keeps readout", bcd2int({16'd0, rd_sm}, 2), 5);
    chk("R5 clear keeps ovr", int'(ovr_sm), 1);
    show(6);
    chk("R7 cleared ovr", int'(ovr_sm), 0);

    // R5 display and clear together
    run_count(7);
    @(negedge clk) gate = 1'b1;
    pulses(4);
    @(negedge clk) begin gate = 1'b0; disp_n = 1'b0; clr_n = 1'b0; end
    @(negedge clk) begin disp_n = 1'b1; clr_n = 1'b1; end
    chk("R5 pre-clear value", bcd2int(rd_big, 6), 11);
    show(6);
    chk("R4 after clear", bcd2int(rd_big, 6), 0);

    // R4 clear beats event
    clear();
    @(negedge clk) gate = 1'b1;
    pulses(2);
    @(negedge clk) begin clr_n = 1'b0; evt_in = 1'b1; end
    @(negedge clk) begin clr_n = 1'b1; evt_in = 1'b0; end
    @(negedge clk) gate = 1'b0;
    show(6);
    chk("R4 precedence", bcd2int(rd_big, 6), 0);

    // R8 interval decode sweep
    for (int s = 0; s < 8; s++) begin
      show(s);
      chk("R8 dp", int'(dp_big), s % 3);
      chk("R8 unit", int'(unit_big), (s < 3) ? 2 : (s < 6) ? 1 : 0);
      chk("R8 dp small", int'(dp_sm), s % 3);
    end
    chk("R1 digits decimal", int'(rd_big[3:0] <= 4'd9), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule